// File: doc/BRIEF.md
# SIMD Lane Value-Locality Reuse Monitor

This block observes a lockstep SIMD datapath of 16 lanes and measures how often a lane could have reused the result of lane 0, the reference lane. In every cycle each lane presents a valid flag and its two 32-bit single-precision operands. A lane other than lane 0 is a reuse candidate when its operand pair equals the reference pair, in either order, once a selectable number of low fraction bits is ignored.

Two saturating counters accumulate results. The reuse counter adds the matching candidate lanes. The issue counter adds every valid lane, lane 0 included, so the ratio between them can reach at most 15/16. Software selects a counter with a one-bit read select, divides the two values itself, and zeroes both with a synchronous clear. A two-bit preset chooses exact matching or one of two relaxed tolerances.

Top module: `simd_reuse_monitor`

## Requirements
- R1: The issue counter adds, in every cycle, the number of lanes 0 to 15 whose valid bit is high. Lane 0 is included.
- R2: The reuse counter adds, in every cycle, the number of valid lanes 1 to 15 whose operands match lane 0. Lane 0 never counts itself, so a cycle adds at most 15.
- R3: A lane matches when its operand A equals the reference A and its operand B equals the reference B, bit for bit, outside the masked bits.
- R4: A lane also matches when its A equals the reference B and its B equals the reference A, which covers commutative operations.
- R5: preset_i selects the tolerance. 0 masks nothing. 1 ignores fraction bits [10:0] of every operand. 2 ignores fraction bits [11:0]. 3 behaves like 0.
- R6: A lane whose valid bit is low adds to neither counter. When lane 0 is not valid, no lane matches in that cycle, but valid lanes still add to the issue counter.
- R7: Inputs sampled at clock edge k appear on rd_data_o after edge k+1 and not earlier. Results from successive cycles accumulate.
- R8: Each counter saturates at 2^CNT_W-1 and does not wrap.
- R9: clear_i high at a clock edge zeroes both counters. It also discards the lane inputs sampled at that edge and at the edge before it.
- R10: rd_sel_i = 0 reads the reuse counter and rd_sel_i = 1 reads the issue counter. Both counters are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous counter clear |
| preset_i | input | 2 | Locality tolerance preset |
| lane_valid_i | input | LANES | Per-lane valid flag; bit i belongs to lane i |
| lane_op_a_i | input | LANES*32 | Operand A of each lane; lane i in bits [32i+31:32i] |
| lane_op_b_i | input | LANES*32 | Operand B of each lane, packed the same way |
| rd_sel_i | input | 1 | Counter select for the read port |
| rd_data_o | output | CNT_W | Selected counter value |

## Verification
A lane pattern sampled at one edge first lands in a stage register. It reaches the counters, and so rd_data_o, at the next edge. The read multiplexer adds no delay. The bench therefore drives each pattern for exactly one edge, follows it with one idle edge, and samples on the falling edge after that.

One directed test reads the counters between the two edges to confirm that nothing shows up early. The clear test places lane inputs at the clear edge and at the edge before it, then confirms that both sets are lost.

// File: rtl/simd_reuse_pkg.sv
package simd_reuse_pkg;
  localparam int unsigned LOOSE_A_BITS = 11;
  localparam int unsigned LOOSE_B_BITS = 12;

  typedef enum logic [1:0] {
    PRESET_EXACT   = 2'd0,
    PRESET_LOOSE_A = 2'd1,
    PRESET_LOOSE_B = 2'd2,
    PRESET_SPARE   = 2'd3
  } preset_e;

  function automatic int unsigned ignored_bits(preset_e p);
    case (p)
      PRESET_LOOSE_A: return LOOSE_A_BITS;
      PRESET_LOOSE_B: return LOOSE_B_BITS;
      default:        return 0;
    endcase
  endfunction
endpackage

// File: rtl/lane_match.sv
module lane_match #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] keep_i,
  input  logic [WORD_W-1:0] ref_a_i,
  input  logic [WORD_W-1:0] ref_b_i,
  input  logic [WORD_W-1:0] op_a_i,
  input  logic [WORD_W-1:0] op_b_i,
  output logic              hit_o
);
  logic [WORD_W-1:0] ra, rb, oa, ob;
  logic straight, crossed;

  always_comb begin
    ra = ref_a_i & keep_i;
    rb = ref_b_i & keep_i;
    oa = op_a_i & keep_i;
    ob = op_b_i & keep_i;
    straight = (oa == ra) && (ob == rb);
    crossed  = (oa == rb) && (ob == ra);
    hit_o    = straight || crossed;
  end
endmodule

// File: rtl/bit_count.sv
module bit_count #(
  parameter int IN_W  = 16,
  parameter int OUT_W = $clog2(IN_W + 1)
) (
  input  logic [IN_W-1:0]  bits_i,
  output logic [OUT_W-1:0] count_o
);
  always_comb begin
    count_o = '0;
    for (int i = 0; i < IN_W; i++) count_o = count_o + OUT_W'(bits_i[i]);
  end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int CNT_W = 32,
  parameter int INC_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W:0] sum;

  assign sum = {1'b0, count_o} + (CNT_W+1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         count_o <= '0;
    else if (clear_i)    count_o <= '0;
    else if (sum[CNT_W]) count_o <= '1;
    else                 count_o <= sum[CNT_W-1:0];
  end
endmodule

// File: rtl/simd_reuse_monitor.sv
module simd_reuse_monitor
  import simd_reuse_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic [1:0]              preset_i,
  input  logic [LANES-1:0]        lane_valid_i,
  input  logic [LANES*WORD_W-1:0] lane_op_a_i,
  input  logic [LANES*WORD_W-1:0] lane_op_b_i,
  input  logic                    rd_sel_i,
  output logic [CNT_W-1:0]        rd_data_o
);
  localparam int SUM_W = $clog2(LANES + 1);

  logic [WORD_W-1:0] keep;
  logic [LANES-1:0]  hit, match_vec;
  logic [SUM_W-1:0]  match_sum, issue_sum;
  logic [SUM_W-1:0]  stg_match_q, stg_issue_q;
  logic [CNT_W-1:0]  reuse_cnt, issue_cnt;

  always_comb keep = {WORD_W{1'b1}} << ignored_bits(preset_e'(preset_i));

  assign hit[0] = 1'b0;  // reference lane never counts itself

  for (genvar i = 1; i < LANES; i++) begin : g_lane
    lane_match #(.WORD_W(WORD_W)) u_match (
      .keep_i  (keep),
      .ref_a_i (lane_op_a_i[WORD_W-1:0]),
      .ref_b_i (lane_op_b_i[WORD_W-1:0]),
      .op_a_i  (lane_op_a_i[i*WORD_W +: WORD_W]),
      .op_b_i  (lane_op_b_i[i*WORD_W +: WORD_W]),
      .hit_o   (hit[i])
    );
  end

  assign match_vec = hit & lane_valid_i & {LANES{lane_valid_i[0]}};

  bit_count #(.IN_W(LANES), .OUT_W(SUM_W)) u_cnt_match (
    .bits_i(match_vec), .count_o(match_sum));
  bit_count #(.IN_W(LANES), .OUT_W(SUM_W)) u_cnt_issue (
    .bits_i(lane_valid_i), .count_o(issue_sum));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_match_q <= '0;
      stg_issue_q <= '0;
    end else if (clear_i) begin
      stg_match_q <= '0;
      stg_issue_q <= '0;
    end else begin
      stg_match_q <= match_sum;
      stg_issue_q <= issue_sum;
    end
  end

  sat_counter #(.CNT_W(CNT_W), .INC_W(SUM_W)) u_reuse (
    .clk_i, .rst_ni, .clear_i, .inc_i(stg_match_q), .count_o(reuse_cnt));
  sat_counter #(.CNT_W(CNT_W), .INC_W(SUM_W)) u_issue (
    .clk_i, .rst_ni, .clear_i, .inc_i(stg_issue_q), .count_o(issue_cnt));

  assign rd_data_o = rd_sel_i ? issue_cnt : reuse_cnt;
endmodule

// File: rtl/simd_reuse_monitor_chk.sv
module simd_reuse_monitor_chk #(
  parameter int LANES = 16,
  parameter int CNT_W = 32,
  parameter int SUM_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic [LANES-1:0] lane_valid_i,
  input logic [SUM_W-1:0] stg_match_q,
  input logic [SUM_W-1:0] stg_issue_q,
  input logic [CNT_W-1:0] reuse_cnt,
  input logic [CNT_W-1:0] issue_cnt
);
  localparam logic [CNT_W-1:0] HEADROOM = {CNT_W{1'b1}} - CNT_W'(LANES);

  a_r2_reuse_le_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reuse_cnt <= issue_cnt);

  a_r2_stage_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stg_match_q < SUM_W'(LANES)) && (stg_match_q <= stg_issue_q));

  a_r6_ref_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lane_valid_i[0] |=> stg_match_q == '0);

  a_r6_idle_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_valid_i == '0 |=> stg_issue_q == '0);

  a_r9_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (reuse_cnt == '0) && (issue_cnt == '0) && (stg_issue_q == '0));

  a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> issue_cnt >= $past(issue_cnt));

  a_r7_accumulate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && issue_cnt < HEADROOM)
      |=> issue_cnt == $past(issue_cnt) + CNT_W'($past(stg_issue_q)));
endmodule

bind simd_reuse_monitor simd_reuse_monitor_chk #(
  .LANES(LANES), .CNT_W(CNT_W), .SUM_W(SUM_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clear_i      (clear_i),
  .lane_valid_i (lane_valid_i),
  .stg_match_q  (stg_match_q),
  .stg_issue_q  (stg_issue_q),
  .reuse_cnt    (reuse_cnt),
  .issue_cnt    (issue_cnt)
);

// File: tb/simd_reuse_monitor_test.sv
`timescale 1ns/1ps
module simd_reuse_monitor_test;
  localparam int LANES = 16;
  localparam int W     = 32;
  localparam int CW    = 10;
  localparam logic [W-1:0] REF_A = 32'h3F80_0000;
  localparam logic [W-1:0] REF_B = 32'h4000_0000;
  localparam logic [CW-1:0] CMAX = '1;

  typedef struct packed {
    logic [1:0]  preset;
    logic [15:0] valid;
    logic [15:0] diff;
    logic [15:0] swap;
    logic [31:0] delta;
    logic [4:0]  exp_reuse;
    logic [4:0]  exp_issue;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'hFFFF, 16'h0000, 16'h0000, 32'h0,     5'd15, 5'd16}, // R2 all match
    '{2'd0, 16'hFFFF, 16'h001E, 16'h0000, 32'h1,     5'd11, 5'd16}, // R3 exact lsb diff
    '{2'd1, 16'hFFFF, 16'h001E, 16'h0000, 32'h7FF,   5'd15, 5'd16}, // R5 within 11 bits
    '{2'd1, 16'hFFFF, 16'h001E, 16'h0000, 32'h800,   5'd11, 5'd16}, // R5 bit 11 seen
    '{2'd2, 16'hFFFF, 16'h001E, 16'h0000, 32'h800,   5'd15, 5'd16}, // R5 bit 11 hidden
    '{2'd2, 16'hFFFF, 16'h001E, 16'h0000, 32'h1000,  5'd11, 5'd16}, // R5 bit 12 seen
    '{2'd0, 16'hFFFF, 16'h0000, 16'hFF00, 32'h0,     5'd15, 5'd16}, // R4 swapped
    '{2'd0, 16'h00FF, 16'h0000, 16'h0000, 32'h0,     5'd7,  5'd8},  // R6 half valid
    '{2'd0, 16'hFFFE, 16'h0000, 16'h0000, 32'h0,     5'd0,  5'd15}, // R6 ref invalid
    '{2'd3, 16'hFFFF, 16'h001E, 16'h0000, 32'h1,     5'd11, 5'd16}, // R5 spare=exact
    '{2'd0, 16'h0000, 16'h0000, 16'h0000, 32'h0,     5'd0,  5'd0},  // R6 idle
    '{2'd0, 16'h8001, 16'h8000, 16'h0000, 32'h1,     5'd0,  5'd2}   // R1 sparse
  };

  logic                clk = 0, rst_ni = 0, clear = 0, rd_sel = 0;
  logic [1:0]          preset = 0;
  logic [LANES-1:0]    valid = 0;
  logic [LANES*W-1:0]  op_a = 0, op_b = 0;
  logic [CW-1:0]       rd_data;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;

  simd_reuse_monitor #(.LANES(LANES), .WORD_W(W), .CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear), .preset_i(preset),
    .lane_valid_i(valid), .lane_op_a_i(op_a), .lane_op_b_i(op_b),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data));

  task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic read_both(output logic [CW-1:0] r, output logic [CW-1:0] s);
    rd_sel = 0; #0.5; r = rd_data;
    rd_sel = 1; #0.5; s = rd_data;
  endtask

  task automatic drive(input vec_t v);
    preset = v.preset;
    valid  = v.valid;
    for (int i = 0; i < LANES; i++) begin
      logic [W-1:0] a, b;
      a = v.diff[i] ? (REF_A ^ v.delta) : REF_A;
      b = REF_B;
      if (v.swap[i]) begin
        op_a[i*W +: W] = b; op_b[i*W +: W] = a;
      end else begin
        op_a[i*W +: W] = a; op_b[i*W +: W] = b;
      end
    end
  endtask

  task automatic idle();
    valid = '0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); idle(); clear = 1;
    @(negedge clk); clear = 0;
  endtask

  initial begin
    logic [CW-1:0] r, s;
    repeat (3) @(negedge clk);
    read_both(r, s);
    check("R10 reset reuse", r, 0);
    check("R10 reset issue", s, 0);
    rst_ni = 1;

    for (int k = 0; k < NV; k++) begin
      pulse_clear();
      drive(VECS[k]);
      @(negedge clk); idle();
      @(negedge clk);
      read_both(r, s);
      check($sformatf("R2 vec%0d reuse", k), r, CW'(VECS[k].exp_reuse));
      check($sformatf("R1 vec%0d issue", k), s, CW'(VECS[k].exp_issue));
    end

    // R7 latency and accumulation
    pulse_clear();
    drive(VECS[0]);
    @(negedge clk); drive(VECS[7]);
    read_both(r, s);
    check("R7 not yet visible", s, 0);
    @(negedge clk); idle();
    read_both(r, s);
    check("R7 first cycle reuse", r, 15);
    check("R7 first cycle issue", s, 16);
    @(negedge clk);
    read_both(r, s);
    check("R7 accumulated reuse", r, 22);
    check("R7 accumulated issue", s, 24);

    // R9 clear discards inputs at clear edge and the edge before
    drive(VECS[0]);
    @(negedge clk); clear = 1;
    @(negedge clk); clear = 0; idle();
    @(negedge clk);
    read_both(r, s);
    check("R9 cleared reuse", r, 0);
    check("R9 cleared issue", s, 0);

    // R8 saturation
    drive(VECS[0]);
    repeat (64) @(negedge clk);
    idle();
    @(negedge clk);
    read_both(r, s);
    check("R8 issue saturated", s, CMAX);
    check("R8 reuse below max", r, 960);
    drive(VECS[0]);
    repeat (5) @(negedge clk);
    idle();
    repeat (2) @(negedge clk);
    read_both(r, s);
    check("R8 reuse saturated", r, CMAX);
    check("R8 issue held", s, CMAX);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule